// File: doc/BRIEF.md
# Framebuffer to Column-Byte Packer

This block walks an 84-column by 48-row frame of 16-bit pixels held row-major in a synchronous memory. It emits the frame as a stream of bytes, each one a vertical strip of eight pixels, in the order a monochrome display with vertical auto-increment consumes them. Each pixel is reduced to a single on/off bit: every pixel word other than zero lights its dot.

A one-cycle `start_i` pulse launches a frame. The block then issues one memory read per cycle. It collects eight returned pixels into a byte and offers that byte on a valid/ready output. The block runs the strips of one column top to bottom, then steps to the next column. A one-cycle `done_o` pulse marks the hand-off of the final byte. A new frame can be launched only after that pulse.

Top module: `fb_colpack`

## Requirements
- R1: A pixel word equal to 16'h0000 gives a 0 bit. Any other value, including one with only bit 0 or only bit 15 set, gives a 1 bit.
- R2: Bit i of an output byte (i = 0..7) is the pixel at row 8*b + i of strip b. Bit 0 is therefore the topmost pixel of the strip.
- R3: Each memory read uses address row*84 + column. Every address issued is below 4032.
- R4: A frame is exactly 504 bytes. The column runs 0 to 83 in the outer position, and the strip index runs 0 to 5 in the inner position.
- R5: Read data is taken one cycle after `mem_rd_o`. While `byte_ready_i` stays high, reads are issued on consecutive cycles without gaps. The whole frame, from the start pulse to `done_o`, takes between 4032 and 4040 cycles.
- R6: While `byte_valid_o` is high and `byte_ready_i` is low, `byte_valid_o` stays high on the next cycle and `byte_data_o` keeps its value.
- R7: `done_o` is high for exactly one cycle, on the cycle after the 504th byte is accepted. `busy_o` is high from launch until `done_o`. A `start_i` pulse while `busy_o` is high changes neither the byte stream nor its length.
- R8: After reset, `mem_rd_o`, `byte_valid_o`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame launch pulse |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 12 | Pixel address |
| mem_data_i | input | 16 | Pixel word, one cycle after the strobe |
| byte_valid_o | output | 1 | Output byte available |
| byte_data_o | output | 8 | Packed strip, bit 0 on top |
| byte_ready_i | input | 1 | Consumer accepts byte |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Last byte accepted |

## Verification
The hardest case to reach is a byte completing while the previous byte is still waiting in the output register. In that case the eighth read of a strip must be held back, and no pixel still in flight may be lost. The bench reaches it by dropping `byte_ready_i` at random, with per-frame probabilities from heavy to light. Under those patterns it compares every accepted byte against a model computed from the memory image. Directed frames of all-zero pixels and of single-bit pixel words cover the threshold edges. A start pulse injected mid-frame covers the ignored-restart case.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  localparam int STRIP_H = 8;

  typedef struct packed {
    logic strip_end;
    logic frame_end;
  } rd_tag_t;
endpackage

// File: rtl/fcp_addr_gen.sv
module fcp_addr_gen
  import fcp_pkg::*;
#(
  parameter int COLS   = 84,
  parameter int ROWS   = 48,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              out_free_i,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output rd_tag_t           tag_o
);
  localparam int BANKS  = ROWS / STRIP_H;
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int BIT_W  = $clog2(STRIP_H);

  logic [COL_W-1:0]  col_q,  col_n;
  logic [BANK_W-1:0] bank_q, bank_n;
  logic [BIT_W-1:0]  bit_q,  bit_n;
  logic              active_q, active_n;
  logic              bit_end, bank_end, col_end;
  logic [ADDR_W-1:0] row_w;

  assign bit_end  = (bit_q  == BIT_W'(STRIP_H - 1));
  assign bank_end = (bank_q == BANK_W'(BANKS - 1));
  assign col_end  = (col_q  == COL_W'(COLS - 1));

  // The eighth read of a strip waits until the output slot will be free
  assign rd_o = active_q && (!bit_end || out_free_i);

  assign row_w  = ADDR_W'(bank_q) * ADDR_W'(STRIP_H) + ADDR_W'(bit_q);
  assign addr_o = row_w * ADDR_W'(COLS) + ADDR_W'(col_q);

  assign tag_o.strip_end = bit_end;
  assign tag_o.frame_end = bit_end && bank_end && col_end;

  always_comb begin
    col_n    = col_q;
    bank_n   = bank_q;
    bit_n    = bit_q;
    active_n = active_q;
    if (launch_i) begin
      col_n    = '0;
      bank_n   = '0;
      bit_n    = '0;
      active_n = 1'b1;
    end else if (rd_o) begin
      if (!bit_end) begin
        bit_n = bit_q + 1'b1;
      end else begin
        bit_n = '0;
        if (!bank_end) begin
          bank_n = bank_q + 1'b1;
        end else begin
          bank_n = '0;
          if (!col_end) begin
            col_n = col_q + 1'b1;
          end else begin
            col_n    = '0;
            active_n = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q    <= '0;
      bank_q   <= '0;
      bit_q    <= '0;
      active_q <= 1'b0;
    end else begin
      col_q    <= col_n;
      bank_q   <= bank_n;
      bit_q    <= bit_n;
      active_q <= active_n;
    end
  end

  AST_ADDR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |-> (int'(addr_o) < COLS * ROWS)); // R3
  AST_READS_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o && !tag_o.strip_end) |=> active_q); // R5
endmodule

// File: rtl/fcp_bit_pack.sv
module fcp_bit_pack
  import fcp_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_i,
  input  rd_tag_t          tag_i,
  input  logic [PIX_W-1:0] data_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [STRIP_H-1:0] byte_o,
  output logic             last_o
);
  logic                 ret_v_q;
  rd_tag_t              ret_tag_q;
  logic [STRIP_H-2:0]   acc_q, acc_n;
  logic [STRIP_H-1:0]   out_q, out_n;
  logic                 valid_q, valid_n;
  logic                 last_q, last_n;
  logic                 pix_on;
  logic                 load;

  assign pix_on = |data_i;
  assign load   = ret_v_q && ret_tag_q.strip_end;

  always_comb begin
    acc_n   = acc_q;
    out_n   = out_q;
    valid_n = valid_q;
    last_n  = last_q;
    if (valid_q && ready_i) valid_n = 1'b0;
    if (ret_v_q) begin
      if (load) begin
        out_n   = {pix_on, acc_q};
        valid_n = 1'b1;
        last_n  = ret_tag_q.frame_end;
      end else begin
        acc_n = {pix_on, acc_q[STRIP_H-2:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_v_q   <= 1'b0;
      ret_tag_q <= '0;
      acc_q     <= '0;
      out_q     <= '0;
      valid_q   <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      ret_v_q <= rd_i;
      if (rd_i) ret_tag_q <= tag_i;
      acc_q   <= acc_n;
      out_q   <= out_n;
      valid_q <= valid_n;
      last_q  <= last_n;
    end
  end

  assign valid_o = valid_q;
  assign byte_o  = out_q;
  assign last_o  = last_q;

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid_q); // R5
  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(out_q))); // R6
endmodule

// File: rtl/fb_colpack.sv
module fb_colpack
  import fcp_pkg::*;
#(
  parameter int COLS   = 84,
  parameter int ROWS   = 48,
  parameter int PIX_W  = 16,
  parameter int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [PIX_W-1:0]  mem_data_i,
  output logic              byte_valid_o,
  output logic [7:0]        byte_data_o,
  input  logic              byte_ready_i,
  output logic              busy_o,
  output logic              done_o
);
  rd_tag_t rd_tag;
  logic    launch, out_free, last_byte, accept;
  logic    busy_q, busy_n, done_q, done_n;

  assign launch   = start_i && !busy_q;
  assign out_free = !byte_valid_o || byte_ready_i;
  assign accept   = byte_valid_o && byte_ready_i;

  fcp_addr_gen #(.COLS(COLS), .ROWS(ROWS), .ADDR_W(ADDR_W)) i_addr (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .out_free_i(out_free),
    .rd_o(mem_rd_o), .addr_o(mem_addr_o), .tag_o(rd_tag)
  );

  fcp_bit_pack #(.PIX_W(PIX_W)) i_pack (
    .clk(clk), .rst_n(rst_n), .rd_i(mem_rd_o), .tag_i(rd_tag),
    .data_i(mem_data_i), .ready_i(byte_ready_i), .valid_o(byte_valid_o),
    .byte_o(byte_data_o), .last_o(last_byte)
  );

  always_comb begin
    done_n = accept && last_byte;
    busy_n = busy_q;
    if (launch)      busy_n = 1'b1;
    else if (done_n) busy_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mem_rd_o && !byte_valid_o)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(byte_valid_o && byte_ready_i)); // R7
endmodule

// File: tb/test_fb_colpack.sv
module test_fb_colpack;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 84;
  localparam int NR = 48;
  localparam int NB = NR / 8;
  localparam int NBYTES = NC * NB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        mem_rd_o;
  logic [11:0] mem_addr_o;
  logic [15:0] mem_data_i;
  logic        byte_valid_o;
  logic [7:0]  byte_data_o;
  logic        byte_ready_i = 1'b0;
  logic        busy_o, done_o;

  logic [15:0] mem [NC*NR];
  int tests = 0;
  int fails = 0;
  bit addr_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_colpack i_fb_colpack (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mem_rd_o(mem_rd_o),
    .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o),
    .byte_ready_i(byte_ready_i), .busy_o(busy_o), .done_o(done_o)
  );

  always_ff @(posedge clk) begin
    if (mem_rd_o) mem_data_i <= (int'(mem_addr_o) < NC*NR) ? mem[mem_addr_o] : 16'hDEAD;
  end

  always @(negedge clk) if (mem_rd_o && int'(mem_addr_o) >= NC*NR) addr_bad = 1;

  function automatic logic [7:0] exp_byte(input int k);
    int c = k / NB;
    int b = k % NB;
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) r[i] = (mem[(b*8+i)*NC + c] != 16'h0);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0: all zero, 1: single-bit words with some zeros, 2: random mix
  task automatic fill(input int mode);
    for (int a = 0; a < NC*NR; a++) begin
      case (mode)
        0: mem[a] = 16'h0;
        1: mem[a] = ($urandom % 3 == 0) ? 16'h0 : (16'h1 << ($urandom % 16));
        default: mem[a] = ($urandom % 2) ? 16'h0 : 16'($urandom % 65535 + 1);
      endcase
    end
    mem[0] = 16'h0001;
    mem[NC] = 16'h8000;
  endtask

  task automatic run_frame(input int pct, input bit mid_start, input string req);
    int k = 0, dones = 0, cyc = 0, bad = 0;
    bit hold = 0;
    logic [7:0] held = '0;
    logic [7:0] e;
    addr_bad = 0;
    @(negedge clk);
    start_i = 1'b1;
    while (dones == 0 && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      start_i = (mid_start && (cyc == 900 || cyc == 2500)) ? 1'b1 : 1'b0;
      if (hold && !(byte_valid_o && byte_data_o == held)) begin
        bad++;
        check(0, "R6", {byte_valid_o, byte_data_o}, {1'b1, held});
      end
      if (done_o) begin
        dones++;
        check(k == NBYTES, "R4 R7", k, NBYTES);
      end
      byte_ready_i = ($urandom % 100) < pct;
      if (byte_valid_o && byte_ready_i) begin
        e = (k < NBYTES) ? exp_byte(k) : 8'h00;
        if (byte_data_o !== e) begin
          bad++;
          check(0, req, byte_data_o, e);
        end
        k++;
      end
      hold = byte_valid_o && !byte_ready_i;
      held = byte_data_o;
    end
    check(bad == 0, req, bad, 0);
    check(dones == 1, "R7", dones, 1);
    check(!addr_bad, "R3", addr_bad, 0);
    if (pct == 100) check(cyc >= 4032 && cyc <= 4040, "R5", cyc, 4035);
    @(negedge clk);
    check(!done_o && !busy_o, "R7", {done_o, busy_o}, 0);
    byte_ready_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!mem_rd_o && !byte_valid_o && !busy_o && !done_o, "R8",
          {mem_rd_o, byte_valid_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_rd_o && !byte_valid_o && !busy_o, "R8",
          {mem_rd_o, byte_valid_o, busy_o}, 0);
    fill(0); run_frame(100, 0, "R1");
    fill(1); run_frame(100, 0, "R1");
    fill(2); run_frame(100, 0, "R2");
    fill(2); run_frame(40, 1, "R2");
    fill(1); run_frame(85, 0, "R4");
    fill(2); run_frame(10, 0, "R6");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule